// File: doc/BRIEF.md
# Flash programming sequencer

This block sequences byte programming, lock-bit programming, whole-array erase, verify reads and identity-byte reads for an on-chip code array of `2**ADDR_W` bytes. The array is held as a register model that comes out of reset blank, with every byte at FFH. A low-going program strobe `prog_n` starts each operation, and the 2-bit `op` code selects which operation it is. A write starts on the rising edge of the strobe and runs for a fixed number of clock cycles (`WRITE_CYC`). For that whole time `ready` is low, and a read of the byte being written shows the inverse of its new bit 7. An erase takes place only when the strobe is held low for `ERASE_CYC` cycles.

Programming merges new data into a byte with a bitwise AND, so a byte that is not blank can only return to FFH through an erase. There are three lock bits. Setting lock 1 or lock 2 hides the array from verify reads. Only an erase clears the lock bits, and their values are never read out. A part is built for either a high or a low programming voltage (`HV_PART`). It accepts programming and erase only while `hv_en` matches that variant. The third identity byte reports which variant the part is.

The controller is a four-state machine:
- `S_IDLE`: waits for a falling edge of `prog_n` and then goes to `S_LOW`.
- `S_LOW`: counts how long the strobe stays low.
  - A rising edge with a program or lock op, and a matching voltage, goes to `S_BUSY`. Any other rising edge goes back to `S_IDLE`.
  - With the erase op, the `ERASE_CYC`-th low sample erases the array and goes to `S_DRAIN`.
- `S_BUSY`: counts out the write and returns to `S_IDLE` on the last cycle, where the write commits.
- `S_DRAIN`: waits for `prog_n` to go high and then returns to `S_IDLE`.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `ready` is 1, every array byte reads FFH and all lock bits are clear.
- R2: With `op`=01 (program) and `hv_en` matching, a falling then rising `prog_n` starts a write. `ready` is 0 from the clock edge that samples the rise for exactly `WRITE_CYC` cycles, then returns to 1.
- R3: A program write stores the old byte ANDed with the `wdata` latched at the strobe rise, so a write can only clear bits.
- R4: While a write is busy and no read-blocking lock is set, reading its address gives the inverse of the new bit 7 on bit 7 and the old bits 6:0. Once `ready` returns, the true byte reads back.
- R5: A `prog_n` falling edge sampled while `ready` is 0 is ignored, even if the strobe rises after the write ends. `ready` stays 1 afterwards and the target byte is unchanged.
- R6: With `op`=10 (erase) and `hv_en` matching, `prog_n` sampled low on `ERASE_CYC` consecutive edges sets every byte to FFH and clears all lock bits. `ready` stays 1 throughout.
- R7: An erase-op low pulse shorter than `ERASE_CYC` cycles changes neither the array nor the lock bits.
- R8: With `op`=11 (lock), a write sets lock 1, 2 or 3 for `wdata[1:0]` = 0, 1 or 2; the value 3 sets nothing. While lock 1 or lock 2 is set, every non-identity read returns FFH. Lock 3 has no effect on reads.
- R9: Lock bits are never cleared by program or lock writes, and they are cleared by an erase.
- R10: With `op`=00 and `sig_sel_n`=00, a read gives 1EH at 030H, 51H at 031H, and at 032H FFH for a high-voltage part or 05H for a low-voltage part. Any other address gives FFH, and lock bits do not affect these reads.
- R11: When `hv_en` differs from the part's variant, program, lock and erase strobes leave `ready` at 1 and change nothing.
- R12: With `op`=00 and `sig_sel_n` not 00, a read of an unlocked array returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Data to program, or lock index in bits 1:0 |
| op | input | 2 | 00 verify, 01 program, 10 erase, 11 lock |
| sig_sel_n | input | 2 | Both low selects identity bytes during verify |
| prog_n | input | 1 | Program strobe, active low |
| hv_en | input | 1 | Programming voltage present flag |
| rdata | output | 8 | Read data |
| ready | output | 1 | 1 when no write is in progress |

## Verification
The assertions assume that `prog_n`, `op`, `addr` and `wdata` change only between clock edges. They also assume that `op` stays fixed while the strobe is low, and that `ADDR_W` is at least 6 so that the identity addresses exist. The bench drives every input on the falling clock edge and sets `op` before it lowers the strobe. The rising-edge ordering and erase-length boundaries are therefore decided only by the number of rising edges that sample each level. The bench samples the combinational read path one time unit after the inputs settle.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [1:0] {
        OP_VERIFY = 2'b00,
        OP_PROG   = 2'b01,
        OP_ERASE  = 2'b10,
        OP_LOCK   = 2'b11
    } fp_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOW,
        S_BUSY,
        S_DRAIN
    } fp_state_e;

    localparam logic [7:0] BLANK_BYTE  = 8'hFF;
    localparam logic [7:0] ID_MAKER    = 8'h1E;
    localparam logic [7:0] ID_MODEL    = 8'h51;
    localparam logic [7:0] ID_VOLT_HI  = 8'hFF;
    localparam logic [7:0] ID_VOLT_LO  = 8'h05;
    localparam int         ID_BASE     = 48;

endpackage

// File: rtl/fps_code_array.sv
module fps_code_array
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wbyte,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rbyte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Cells can only lose ones on a write; erase restores all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
        end else if (wr_en) begin
            mem[waddr] <= mem[waddr] & wbyte;
        end
    end

    assign rbyte = mem[raddr];

endmodule

// File: rtl/fps_sig_rom.sv
module fps_sig_rom
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int HV_PART = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        id_byte
);
    localparam logic [ADDR_W-1:0] A_MAKER = ADDR_W'(ID_BASE);
    localparam logic [ADDR_W-1:0] A_MODEL = ADDR_W'(ID_BASE + 1);
    localparam logic [ADDR_W-1:0] A_VOLT  = ADDR_W'(ID_BASE + 2);
    localparam logic [7:0]        VOLT_ID = (HV_PART != 0) ? ID_VOLT_HI : ID_VOLT_LO;

    always_comb begin
        if (addr == A_MAKER)      id_byte = ID_MAKER;
        else if (addr == A_MODEL) id_byte = ID_MODEL;
        else if (addr == A_VOLT)  id_byte = VOLT_ID;
        else                      id_byte = BLANK_BYTE;
    end

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 18000,
    parameter int ERASE_CYC = 120000,
    parameter int HV_PART   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op,
    input  logic              prog_n,
    input  logic              hv_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              ready,
    output logic              erase_go,
    output logic              commit_array,
    output logic              poll_active,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [7:0]        pend_data,
    output logic [2:0]        lock_q
);
    localparam int CNT_MAX = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0] ER_LAST = CNT_W'(ERASE_CYC - 1);

    fp_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             prog_q;
    logic             pend_lock;
    logic             hv_ok, is_write, erase_hit, start_write, commit_go;

    always_comb begin
        hv_ok       = (hv_en == (HV_PART != 0));
        is_write    = (op == OP_PROG) || (op == OP_LOCK);
        erase_hit   = (state == S_LOW) && !prog_n && (op == OP_ERASE) && hv_ok && (cnt == ER_LAST);
        start_write = (state == S_LOW) && prog_n && is_write && hv_ok;
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (prog_q && !prog_n) nxt = S_LOW;
            S_LOW: begin
                if (prog_n)         nxt = start_write ? S_BUSY : S_IDLE;
                else if (erase_hit) nxt = S_DRAIN;
            end
            S_BUSY:  if (cnt == WR_LAST) nxt = S_IDLE;
            S_DRAIN: if (prog_n) nxt = S_IDLE;
        endcase
    end

    // State register with its cycle counter and strobe history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            prog_q <= 1'b1;
        end else begin
            state  <= nxt;
            prog_q <= prog_n;
            unique case (state)
                S_IDLE:  cnt <= CNT_W'(1);
                S_LOW: begin
                    if (start_write)     cnt <= '0;
                    else if (cnt != ER_LAST) cnt <= cnt + 1'b1;
                end
                S_BUSY:  cnt <= cnt + 1'b1;
                S_DRAIN: cnt <= cnt;
            endcase
        end
    end

    // Operation latched on the strobe rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_data <= BLANK_BYTE;
            pend_lock <= 1'b0;
        end else if (start_write) begin
            pend_addr <= addr;
            pend_data <= wdata;
            pend_lock <= (op == OP_LOCK);
        end
    end

    // Lock bits: set by lock writes, cleared only by erase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (erase_hit) begin
            lock_q <= '0;
        end else if (commit_go && pend_lock && (pend_data[1:0] != 2'd3)) begin
            lock_q[pend_data[1:0]] <= 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        ready        = (state != S_BUSY);
        commit_go    = (state == S_BUSY) && (cnt == WR_LAST);
        commit_array = commit_go && !pend_lock;
        poll_active  = (state == S_BUSY) && !pend_lock;
        erase_go     = erase_hit;
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 18000,
    parameter int ERASE_CYC = 120000,
    parameter int HV_PART   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [1:0]        op,
    input  logic [1:0]        sig_sel_n,
    input  logic              prog_n,
    input  logic              hv_en,
    output logic [7:0]        rdata,
    output logic              ready
);
    logic              erase_go, commit_array, poll_active;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0]        pend_data;
    logic [2:0]        lock_q;
    logic [7:0]        arr_byte, id_byte;

    fps_ctrl #(
        .ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC),
        .ERASE_CYC(ERASE_CYC), .HV_PART(HV_PART)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .prog_n(prog_n), .hv_en(hv_en),
        .addr(addr), .wdata(wdata), .ready(ready), .erase_go(erase_go),
        .commit_array(commit_array), .poll_active(poll_active),
        .pend_addr(pend_addr), .pend_data(pend_data), .lock_q(lock_q)
    );

    fps_code_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .erase(erase_go), .wr_en(commit_array),
        .waddr(pend_addr), .wbyte(pend_data), .raddr(addr), .rbyte(arr_byte)
    );

    fps_sig_rom #(.ADDR_W(ADDR_W), .HV_PART(HV_PART)) u_sig (
        .addr(addr), .id_byte(id_byte)
    );

    // Read priority: identity bytes, lock blanking, data polling, array
    always_comb begin
        if ((op == OP_VERIFY) && (sig_sel_n == 2'b00))
            rdata = id_byte;
        else if (lock_q[0] || lock_q[1])
            rdata = BLANK_BYTE;
        else if (poll_active && (addr == pend_addr))
            rdata = {~pend_data[7], arr_byte[6:0]};
        else
            rdata = arr_byte;
    end

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 18000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op,
    input logic [1:0]        sig_sel_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              ready,
    input logic [2:0]        lock_q,
    input logic              erase_go,
    input logic              poll_active,
    input logic [ADDR_W-1:0] pend_addr,
    input logic              pend_bit7
);
    localparam int BC_W   = $clog2(WRITE_CYC + 2);
    localparam logic [BC_W-1:0] BC_SAT = BC_W'(WRITE_CYC + 1);
    localparam logic [BC_W-1:0] BC_LIM = BC_W'(WRITE_CYC);
    localparam logic [ADDR_W-1:0] A_ID0 = ADDR_W'(48);

    logic [BC_W-1:0] bcnt;
    logic            id_rd, rd_blocked;

    assign id_rd      = (op == 2'b00) && (sig_sel_n == 2'b00);
    assign rd_blocked = lock_q[0] || lock_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bcnt <= '0;
        else if (ready)      bcnt <= '0;
        else if (bcnt != BC_SAT) bcnt <= bcnt + 1'b1;
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= BC_LIM);                                                    // R2
    AST_POLL_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_active && !id_rd && !rd_blocked && addr == pend_addr) |-> (rdata[7] == ~pend_bit7)); // R4
    AST_LOCK_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(erase_go) |-> ((lock_q & $past(lock_q)) == $past(lock_q))); // R9
    AST_ERASE_CLEARS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> (lock_q == 3'b000));                                   // R6
    AST_ERASE_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> ready);                                                // R6
    AST_LOCKED_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_rd && rd_blocked) |-> (rdata == 8'hFF));                       // R8
    AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && addr == A_ID0) |-> (rdata == 8'h1E));                     // R10

endmodule

bind flash_prog_seq fps_checker #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .sig_sel_n(sig_sel_n), .addr(addr),
    .rdata(rdata), .ready(ready), .lock_q(lock_q), .erase_go(erase_go),
    .poll_active(poll_active), .pend_addr(pend_addr), .pend_bit7(pend_data[7])
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
    import flash_prog_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int WC    = 6;
    localparam int EC    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [1:0]    op = 2'b00;
    logic [1:0]    sig_sel_n = 2'b11;
    logic          prog_n = 1'b1;
    logic          hv_en = 1'b1;
    logic [7:0]    rdata, rdata_lv;
    logic          ready, ready_lv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_prog_seq #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .HV_PART(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .op(op),
        .sig_sel_n(sig_sel_n), .prog_n(prog_n), .hv_en(hv_en),
        .rdata(rdata), .ready(ready)
    );

    flash_prog_seq #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .HV_PART(0)) u_dut_lv (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .op(op),
        .sig_sel_n(sig_sel_n), .prog_n(prog_n), .hv_en(hv_en),
        .rdata(rdata_lv), .ready(ready_lv)
    );

    int         checks = 0;
    int         errors = 0;
    logic [7:0] mem_m [DEPTH];
    logic [2:0] lock_m = 3'b000;

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        return (lock_m[0] || lock_m[1]) ? 8'hFF : mem_m[a];
    endfunction

    task automatic read_chk(input int a, input string req);
        @(negedge clk);
        op = OP_VERIFY; sig_sel_n = 2'b11; addr = AW'(a);
        #1;
        check8(req, rdata, exp_rd(a));
    endtask

    task automatic id_chk(input int a, input logic [7:0] exp, input logic lv, input string req);
        @(negedge clk);
        op = OP_VERIFY; sig_sel_n = 2'b00; addr = AW'(a);
        #1;
        check8(req, lv ? rdata_lv : rdata, exp);
        sig_sel_n = 2'b11;
    endtask

    task automatic prog(input int a, input logic [7:0] d, input logic is_lock, input logic hv);
        int         busy;
        logic [7:0] pexp;
        @(negedge clk);
        op = is_lock ? OP_LOCK : OP_PROG;
        addr = AW'(a); wdata = d; sig_sel_n = 2'b11; hv_en = hv; prog_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        #1;
        if (hv) begin
            check8("R2 ready low after strobe rise", {7'b0, ready}, 8'd0);
            if (!is_lock) begin
                pexp = (lock_m[0] || lock_m[1]) ? 8'hFF : {~d[7], mem_m[a][6:0]};
                check8("R4 polled byte while busy", rdata, pexp);
            end
            busy = 1;
            @(negedge clk);
            while (!ready) begin
                busy++;
                @(negedge clk);
            end
            check8("R2 busy length", 8'(busy), 8'(WC));
            if (is_lock) begin
                if (d[1:0] != 2'd3) lock_m[d[1:0]] = 1'b1;
            end else begin
                mem_m[a] = mem_m[a] & d;
                #1;
                check8("R4 true data after completion", rdata, exp_rd(a));
            end
        end else begin
            check8("R11 mismatched voltage keeps ready", {7'b0, ready}, 8'd1);
        end
        hv_en = 1'b1;
    endtask

    task automatic erase(input int n);
        @(negedge clk);
        op = OP_ERASE; sig_sel_n = 2'b11; prog_n = 1'b0;
        repeat (n) @(negedge clk);
        #1;
        check8("R6 ready high during erase hold", {7'b0, ready}, 8'd1);
        prog_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (n >= EC) begin
            for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
            lock_m = 3'b000;
        end
    endtask

    task automatic finish_report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_report();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check8("R1 ready after reset", {7'b0, ready}, 8'd1);
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R1 blank after reset");

        id_chk(48, 8'h1E, 1'b0, "R10 id byte 0");
        id_chk(49, 8'h51, 1'b0, "R10 id byte 1");
        id_chk(50, 8'hFF, 1'b0, "R10 id byte 2 high-voltage");
        id_chk(51, 8'hFF, 1'b0, "R10 non-id address");
        id_chk(50, 8'h05, 1'b1, "R10 id byte 2 low-voltage");

        for (int a = 0; a < DEPTH; a++) prog(a, 8'(a * 29 + 7), 1'b0, 1'b1);
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R12 verify readback");
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            op = OP_VERIFY; sig_sel_n = 2'b11; addr = AW'(a * 7);
            #1;
            check8("R11 low-voltage part unprogrammed", rdata_lv, 8'hFF);
        end

        for (int a = 0; a < DEPTH; a++) prog(a, 8'(a * 53) ^ 8'hA5, 1'b0, 1'b1);
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R3 AND merge");

        // R5: strobes that fall while busy are discarded
        @(negedge clk);
        op = OP_PROG; addr = AW'(10); wdata = 8'h0F; prog_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        addr = AW'(11); wdata = 8'h00; prog_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        prog_n = 1'b0;
        while (!ready) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        check8("R5 ready stays high after ignored strobe", {7'b0, ready}, 8'd1);
        mem_m[10] = mem_m[10] & 8'h0F;
        read_chk(11, "R5 ignored strobe left byte");
        read_chk(10, "R3 write before ignored strobe");

        prog(5, 8'h00, 1'b0, 1'b0);
        read_chk(5, "R11 mismatched voltage no write");

        erase(EC - 2);
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R7 short erase pulse");

        prog(0, 8'h02, 1'b1, 1'b1);
        for (int a = 0; a < 16; a++) read_chk(a, "R8 lock 3 no read effect");
        prog(0, 8'h00, 1'b1, 1'b1);
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R8 lock 1 blanks reads");
        id_chk(49, 8'h51, 1'b0, "R10 id under lock");
        prog(7, 8'h00, 1'b0, 1'b1);
        read_chk(7, "R9 write keeps lock");

        erase(EC + 2);
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R6 erase to blank");
        prog(3, 8'h5A, 1'b0, 1'b1);
        read_chk(3, "R9 erase cleared lock");

        prog(0, 8'h01, 1'b1, 1'b1);
        read_chk(3, "R8 lock 2 blanks reads");
        erase(EC);
        read_chk(3, "R6 erase at exact length");
        prog(3, 8'h3C, 1'b0, 1'b1);
        read_chk(3, "R6 lock 2 cleared by erase");

        finish_report();
    end

endmodule